// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit control and status register on a microcontroller's special-function-register bus. It holds the start/stop bits for two timers and the trigger-type selects for two external interrupt inputs. It also keeps four hardware-managed request flags. Two of these flags latch timer overflows. The other two latch activity on two active-low external interrupt pins.

A timer overflow pulse sets that timer's flag. When the interrupt controller vectors to the source, it sends a one-cycle acknowledge strobe, and the strobe clears the flag. Each external pin passes through a synchronizer, and its trigger type can be set two ways. In edge mode, a falling edge latches the flag and the acknowledge clears it. In level mode, the flag simply mirrors the inverted synchronized pin.

Software may read the register at any time with no side effects. Software may also write any bit. Each flag is gated with an enable input from outside to form one of four interrupt request lines.

Top module: `tmr_irq_ctl`

## Requirements
- R1: While rst_ni is low, the register reads 0x00 and run_o, tmr_irq_o and ext_irq_o are all zero.
- R2: A write strobe with sfr_addr_i equal to SFR_ADDR (default 0x88) loads the register on that edge, subject to R3, R4, R8 and R9. A write to any other address changes nothing. The bit layout, MSB first, is: timer-1 flag, timer-1 run, timer-0 flag, timer-0 run, ext-1 flag, ext-1 type, ext-0 flag, ext-0 type.
- R3: An ovf_i[x] pulse sets timer flag x (bit 5 for x=0, bit 7 for x=1) on that edge. It wins over an acknowledge or a software clear in the same cycle.
- R4: An ack_tmr_i[x] pulse without a simultaneous overflow clears timer flag x.
- R5: run_o[x] equals run bit x (bit 4 for x=0, bit 6 for x=1).
- R6: tmr_irq_o[x] is high exactly when timer flag x and tmr_en_i[x] are both set.
- R7: With type bit x = 1 (bit 0 for x=0, bit 2 for x=1), a falling edge on ext_n_i[x] sets ext flag x (bit 1 for x=0, bit 3 for x=1). The flag sets on the third rising clock edge after the pin drops, given SYNC_STAGES=2. A pin that stays low does not set the flag again.
- R8: In edge mode, an ack_ext_i[x] pulse clears ext flag x unless a falling edge is detected in the same cycle.
- R9: With type bit x = 0, ext flag x follows the inverted synchronized pin every cycle. Acknowledges and writes do not change the flag beyond a single cycle.
- R10: ext_irq_o[x] is high exactly when ext flag x and ext_en_i[x] are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | ADDR_W | Register bus address |
| sfr_wr_i | input | 1 | Register bus write strobe |
| sfr_wdata_i | input | 8 | Register bus write data |
| sfr_rdata_o | output | 8 | Current register value |
| ovf_i | input | 2 | Timer overflow pulses |
| ack_tmr_i | input | 2 | Timer interrupt acknowledge strobes |
| ext_n_i | input | 2 | Active-low external interrupt pins (asynchronous) |
| ack_ext_i | input | 2 | External interrupt acknowledge strobes |
| tmr_en_i | input | 2 | Timer interrupt enables |
| ext_en_i | input | 2 | External interrupt enables |
| run_o | output | 2 | Timer run enables |
| tmr_irq_o | output | 2 | Gated timer interrupt requests |
| ext_irq_o | output | 2 | Gated external interrupt requests |

## Verification
The bench builds the block with its default parameters: SFR_ADDR of 0x88, an 8-bit address and a two-stage pin synchronizer. The fixed two-stage depth puts the flag-set edge for external interrupts at a known cycle. The bench checks that edge one cycle early and on time. The fixed address lets a write to the neighbouring address 0x89 exercise the decode-miss path. Same-cycle collisions between overflow, acknowledge and write are applied directly. So are switches between edge and level mode while the pin is held low.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned REG_W = 8;

  // bit positions within the register, per channel
  function automatic int unsigned tf_pos(int unsigned ch); return 5 + 2 * ch; endfunction
  function automatic int unsigned tr_pos(int unsigned ch); return 4 + 2 * ch; endfunction
  function automatic int unsigned ie_pos(int unsigned ch); return 1 + 2 * ch; endfunction
  function automatic int unsigned it_pos(int unsigned ch); return 2 * ch;     endfunction
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/tic_tmr_slice.sv
module tic_tmr_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_run_i,
  input  logic wdata_flag_i,
  input  logic ovf_i,
  input  logic ack_i,
  input  logic en_i,
  output logic run_o,
  output logic flag_o,
  output logic irq_o
);
  logic run_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) run_q <= wdata_run_i;
      // hardware set > acknowledge clear > software write
      if (ovf_i)      flag_q <= 1'b1;
      else if (ack_i) flag_q <= 1'b0;
      else if (wr_i)  flag_q <= wdata_flag_i;
    end
  end

  assign run_o  = run_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/tic_ext_slice.sv
module tic_ext_slice #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic wr_i,
  input  logic wdata_mode_i,
  input  logic wdata_flag_i,
  input  logic ack_i,
  input  logic en_i,
  output logic mode_o,
  output logic flag_o,
  output logic irq_o
);
  logic pin_s, pin_prev, fall;
  logic mode_q, flag_q;

  tic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_ni),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev <= 1'b1;
    else         pin_prev <= pin_s;
  end

  assign fall = pin_prev & ~pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) mode_q <= wdata_mode_i;
      if (mode_q) begin
        if (fall)       flag_q <= 1'b1;
        else if (ack_i) flag_q <= 1'b0;
        else if (wr_i)  flag_q <= wdata_flag_i;
      end else begin
        flag_q <= ~pin_s;  // level mode mirrors the pin
      end
    end
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tic_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h88,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  input  logic [1:0]        ovf_i,
  input  logic [1:0]        ack_tmr_i,
  input  logic [1:0]        ext_n_i,
  input  logic [1:0]        ack_ext_i,
  input  logic [1:0]        tmr_en_i,
  input  logic [1:0]        ext_en_i,
  output logic [1:0]        run_o,
  output logic [1:0]        tmr_irq_o,
  output logic [1:0]        ext_irq_o
);
  logic wr_hit;
  logic [NCH-1:0] tf, ie, it;

  assign wr_hit = sfr_wr_i && (sfr_addr_i == SFR_ADDR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tic_tmr_slice u_tmr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_hit),
      .wdata_run_i (sfr_wdata_i[tr_pos(c)]),
      .wdata_flag_i(sfr_wdata_i[tf_pos(c)]),
      .ovf_i       (ovf_i[c]),
      .ack_i       (ack_tmr_i[c]),
      .en_i        (tmr_en_i[c]),
      .run_o       (run_o[c]),
      .flag_o      (tf[c]),
      .irq_o       (tmr_irq_o[c])
    );

    tic_ext_slice #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_ni      (ext_n_i[c]),
      .wr_i        (wr_hit),
      .wdata_mode_i(sfr_wdata_i[it_pos(c)]),
      .wdata_flag_i(sfr_wdata_i[ie_pos(c)]),
      .ack_i       (ack_ext_i[c]),
      .en_i        (ext_en_i[c]),
      .mode_o      (it[c]),
      .flag_o      (ie[c]),
      .irq_o       (ext_irq_o[c])
    );
  end

  assign sfr_rdata_o = {tf[1], run_o[1], tf[0], run_o[0], ie[1], it[1], ie[0], it[0]};
endmodule

// File: rtl/tic_chk.sv
module tic_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h88
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] sfr_addr_i,
  input logic              sfr_wr_i,
  input logic [7:0]        sfr_wdata_i,
  input logic [7:0]        sfr_rdata_o,
  input logic [1:0]        ovf_i,
  input logic [1:0]        ack_tmr_i,
  input logic [1:0]        ack_ext_i,
  input logic [1:0]        tmr_en_i,
  input logic [1:0]        ext_en_i,
  input logic [1:0]        run_o,
  input logic [1:0]        tmr_irq_o,
  input logic [1:0]        ext_irq_o
);
  logic hit;
  assign hit = sfr_wr_i && (sfr_addr_i == SFR_ADDR);

  for (genvar c = 0; c < 2; c++) begin : g_a
    a_r3_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[c] |=> sfr_rdata_o[5+2*c]);
    a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_tmr_i[c] && !ovf_i[c] |=> !sfr_rdata_o[5+2*c]);
    a_r2_flag_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && !ovf_i[c] && !ack_tmr_i[c] |=> sfr_rdata_o[5+2*c] == $past(sfr_wdata_i[5+2*c]));
    a_r2_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> sfr_rdata_o[2*c] == $past(sfr_wdata_i[2*c]));
    a_r2_edge_flag_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && sfr_rdata_o[2*c] && !ack_ext_i[c] && sfr_wdata_i[1+2*c] |=> sfr_rdata_o[1+2*c]);
    a_r5_run_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> run_o[c] == $past(sfr_wdata_i[4+2*c]) && sfr_rdata_o[4+2*c] == run_o[c]);
    a_r2_run_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit |=> $stable(run_o[c]));
    a_r6_tmr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_irq_o[c] |-> tmr_en_i[c] && sfr_rdata_o[5+2*c]);
    a_r10_ext_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_irq_o[c] |-> ext_en_i[c] && sfr_rdata_o[1+2*c]);
  end
endmodule

bind tmr_irq_ctl tic_chk #(.ADDR_W(ADDR_W), .SFR_ADDR(SFR_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sfr_addr_i (sfr_addr_i),
  .sfr_wr_i   (sfr_wr_i),
  .sfr_wdata_i(sfr_wdata_i),
  .sfr_rdata_o(sfr_rdata_o),
  .ovf_i      (ovf_i),
  .ack_tmr_i  (ack_tmr_i),
  .ack_ext_i  (ack_ext_i),
  .tmr_en_i   (tmr_en_i),
  .ext_en_i   (ext_en_i),
  .run_o      (run_o),
  .tmr_irq_o  (tmr_irq_o),
  .ext_irq_o  (ext_irq_o)
);

// File: tb/tb_tmr_irq_ctl.sv
`timescale 1ns/1ps
module tb_tmr_irq_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [1:0] ovf = 2'b00, ack_t = 2'b00, pin_n = 2'b11, ack_x = 2'b00;
  logic [1:0] en_t = 2'b00, en_x = 2'b00;
  logic [1:0] run, tirq, xirq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_irq_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(addr), .sfr_wr_i(wr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .ovf_i(ovf), .ack_tmr_i(ack_t),
    .ext_n_i(pin_n), .ack_ext_i(ack_x), .tmr_en_i(en_t), .ext_en_i(en_x),
    .run_o(run), .tmr_irq_o(tirq), .ext_irq_o(xirq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    addr = 8'h88; wr = 1'b1; wdata = d;
    cyc(1);
    wr = 1'b0;
  endtask

  // {req[3:0], wr, hit, wdata[7:0], ovf[1:0], ack_tmr[1:0], exp[7:0]}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b1, 8'h50, 2'b00, 2'b00, 8'h50},
    {4'd3, 1'b0, 1'b0, 8'h00, 2'b01, 2'b00, 8'h70},
    {4'd3, 1'b0, 1'b0, 8'h00, 2'b10, 2'b00, 8'hF0},
    {4'd4, 1'b0, 1'b0, 8'h00, 2'b00, 2'b01, 8'hD0},
    {4'd3, 1'b0, 1'b0, 8'h00, 2'b10, 2'b10, 8'hD0},
    {4'd4, 1'b0, 1'b0, 8'h00, 2'b00, 2'b10, 8'h50},
    {4'd2, 1'b1, 1'b0, 8'hFF, 2'b00, 2'b00, 8'h50},
    {4'd9, 1'b1, 1'b1, 8'h0A, 2'b00, 2'b00, 8'h00},
    {4'd2, 1'b1, 1'b1, 8'h20, 2'b00, 2'b00, 8'h20},
    {4'd3, 1'b1, 1'b1, 8'h00, 2'b01, 2'b00, 8'h20},
    {4'd2, 1'b1, 1'b1, 8'h05, 2'b00, 2'b00, 8'h05},
    {4'd2, 1'b0, 1'b0, 8'h00, 2'b00, 2'b00, 8'h05}
  };

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(2);
    chk("R1 reg", rdata, 8'h00);
    chk("R1 outs", {2'b00, run, tirq, xirq}, 8'h00);
    rst_n = 1'b1;
    cyc(1);

    for (int v = 0; v < NV; v++) begin
      addr  = VEC[v][20] ? 8'h88 : 8'h89;
      wr    = VEC[v][21];
      wdata = VEC[v][19:12];
      ovf   = VEC[v][11:10];
      ack_t = VEC[v][9:8];
      cyc(1);
      wr = 1'b0; ovf = 2'b00; ack_t = 2'b00;
      chk($sformatf("R%0d vec%0d", VEC[v][25:22], v), rdata, VEC[v][7:0]);
    end

    // R5: run outputs
    wr_reg(8'h55);
    chk("R5 run", {6'd0, run}, 8'h03);
    // R6: gated timer requests
    en_t = 2'b01; ovf = 2'b11;
    cyc(1);
    ovf = 2'b00;
    chk("R6 tmr_irq", {6'd0, tirq}, 8'h01);
    chk("R3 both flags", rdata, 8'hF5);
    ack_t = 2'b11;
    cyc(1);
    ack_t = 2'b00; en_t = 2'b00;
    chk("R4 ack both", rdata, 8'h55);

    // R7: edge mode set on third edge
    pin_n[0] = 1'b0;
    cyc(2);
    chk("R7 not yet", {7'd0, rdata[1]}, 8'h00);
    cyc(1);
    chk("R7 edge set", {7'd0, rdata[1]}, 8'h01);
    chk("R10 ext_irq off", {6'd0, xirq}, 8'h00);
    en_x = 2'b01;
    #1;
    chk("R10 ext_irq on", {6'd0, xirq}, 8'h01);
    en_x = 2'b00;
    // R8: acknowledge clears in edge mode
    cyc(3);
    ack_x = 2'b01;
    cyc(1);
    ack_x = 2'b00;
    chk("R8 ack clears", {7'd0, rdata[1]}, 8'h00);
    cyc(3);
    chk("R7 held low no reset", {7'd0, rdata[1]}, 8'h00);

    // R9: level mode on channel 0, pin still low
    wr_reg(8'h54);
    cyc(1);
    chk("R9 level follows", {7'd0, rdata[1]}, 8'h01);
    ack_x = 2'b01;
    cyc(1);
    ack_x = 2'b00;
    chk("R9 ack ignored", {7'd0, rdata[1]}, 8'h01);
    wr_reg(8'h54);
    chk("R9 write ignored", {7'd0, rdata[1]}, 8'h01);
    pin_n[0] = 1'b1;
    cyc(2);
    chk("R9 release lag", {7'd0, rdata[1]}, 8'h01);
    cyc(1);
    chk("R9 release", rdata, 8'h54);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset", {rdata[7:2], run}, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule